// File: doc/BRIEF.md
# Path BIP-8 Error Counter

This block watches the payload envelope of a path after descrambling and keeps score of parity errors. Every payload byte of a frame is folded into an even bit-interleaved parity byte, which gives eight parity lanes, one per bit position. When the next frame starts, that result becomes the reference. The parity byte carried in that next frame is then checked against it. Each disagreement adds to a running error count. One input selects whether the count grows by the number of differing bits or by one for each frame that has any difference.

A performance-monitoring strobe copies the running count into a 16-bit holding register and restarts the running count from zero. A second input selects the overflow arithmetic: the running count either wraps or sticks at its maximum until the next strobe clears it. Finding the payload in the frame and descrambling it are done upstream. This block only sees valid-qualified bytes and a frame-start pulse.

Top module: `bip8_path_monitor`

## Requirements
- R1: After reset, `err_hold_o` reads 0 and the block has no frame history.
- R2: The parity of a frame is the XOR of every byte presented with `pay_vld_i` high. Counting starts on the cycle that carries `frame_start_i` (that cycle's byte included) and ends on the cycle before the next `frame_start_i`.
- R3: A parity byte (`par_vld_i` high) is checked against the parity of the previous complete frame. Parity bytes seen before the second `frame_start_i` after reset add nothing.
- R4: With `block_mode_i` = 0, a checked parity byte adds the number of bit positions in which it differs from the reference (0 to 8).
- R5: With `block_mode_i` = 1, a checked parity byte adds 1 if any bit differs and 0 otherwise.
- R6: An increment from a parity byte accepted on clock edge k enters the running count on edge k+1.
- R7: On an edge with `pm_tick_i` high, `err_hold_o` takes the running count as it stood before that edge, and the running count restarts from zero. `err_hold_o` changes on no other edge.
- R8: An increment that enters on the same edge as `pm_tick_i` is not lost. It becomes the first value of the new running count.
- R9: With `saturate_i` = 1, the running count stops at 65535 and stays there until a `pm_tick_i` clears it.
- R10: With `saturate_i` = 0, the running count wraps modulo 65536.
- R11: A parity byte on the same cycle as `frame_start_i` is checked against the parity of the frame that ends on that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_start_i | input | 1 | Pulse on the first cycle of each frame |
| pay_vld_i | input | 1 | Payload byte valid |
| pay_data_i | input | 8 | Descrambled payload byte |
| par_vld_i | input | 1 | Received parity byte valid |
| par_data_i | input | 8 | Received parity byte |
| pm_tick_i | input | 1 | Performance-monitoring interval strobe |
| block_mode_i | input | 1 | 0: count bit errors, 1: count block errors |
| saturate_i | input | 1 | 0: running count wraps, 1: running count saturates |
| err_hold_o | output | 16 | Error count of the last completed interval |

## Verification
The running count and the reference parity are internal, so any fault in them shows up only in `err_hold_o`, and only at the next `pm_tick_i`. A wrong reference byte or a wrong lane fold therefore stays hidden until the interval closes, and then appears as a count that is off by the number of differing lanes. The bench closes intervals often, so a bad frame is seen within a few frames. It also places strobes exactly on and just after the increment edge, so a one-cycle timing slip changes which interval an error lands in. Long runs of all-lanes-wrong frames drive the count past 65535 in both overflow modes, which separates a stuck count from a wrapped one.

// File: rtl/bip8_mon_pkg.sv
// Package: shared mode encodings for the path parity monitor.
// Assumes: mode inputs are single bits driven from static configuration.
package bip8_mon_pkg;
    typedef enum logic {
        CNT_BITS   = 1'b0,
        CNT_BLOCKS = 1'b1
    } count_mode_e;

    typedef enum logic {
        OVF_WRAP     = 1'b0,
        OVF_SATURATE = 1'b1
    } ovf_mode_e;
endpackage

// File: rtl/bip8_accum.sv
// Module: folds payload bytes into an even interleaved parity byte per frame
// and keeps the previous frame's parity as the reference.
// Assumes: frame_start_i marks the first cycle of a frame, and that cycle's
// payload byte belongs to the new frame. The reference outputs give the value
// a parity byte in the current cycle must be checked against, including on a
// frame_start cycle.
module bip8_accum #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start_i,
    input  logic              pay_vld_i,
    input  logic [DATA_W-1:0] pay_data_i,
    output logic [DATA_W-1:0] ref_o,
    output logic              ref_vld_o
);
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] ref_q;
    logic              ref_vld_q;
    logic              seen_q;
    logic [DATA_W-1:0] byte_in;

    // Masks a byte that is not valid so the fold only sees real payload.
    always_comb begin
        byte_in = pay_vld_i ? pay_data_i : '0;
    end

    // Runs the parity fold, restarting on frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (frame_start_i) begin
            acc_q <= byte_in;
        end else begin
            acc_q <= acc_q ^ byte_in;
        end
    end

    // Moves the finished frame's parity into the reference on frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q     <= '0;
            ref_vld_q <= 1'b0;
            seen_q    <= 1'b0;
        end else if (frame_start_i) begin
            ref_q     <= acc_q;
            ref_vld_q <= seen_q;
            seen_q    <= 1'b1;
        end
    end

    // Gives the reference that applies to this cycle's parity byte.
    always_comb begin
        ref_o     = frame_start_i ? acc_q  : ref_q;
        ref_vld_o = frame_start_i ? seen_q : ref_vld_q;
    end
endmodule

// File: rtl/bip8_compare.sv
// Module: checks a received parity byte against the reference and registers
// the increment: the number of differing lanes, or 1 for any difference.
// Assumes: block_mode_i is stable while a parity byte is being checked.
module bip8_compare #(
    parameter int DATA_W  = 8,
    parameter int DELTA_W = $clog2(DATA_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               par_vld_i,
    input  logic [DATA_W-1:0]  par_data_i,
    input  logic [DATA_W-1:0]  ref_i,
    input  logic               ref_vld_i,
    input  logic               block_mode_i,
    output logic               inc_vld_o,
    output logic [DELTA_W-1:0] inc_o
);
    import bip8_mon_pkg::*;

    logic [DATA_W-1:0]  diff;
    logic [DELTA_W-1:0] lanes_bad;
    logic [DELTA_W-1:0] inc_d;
    count_mode_e        mode;

    // Counts the lanes whose received parity disagrees with the reference.
    always_comb begin
        diff      = par_data_i ^ ref_i;
        lanes_bad = '0;
        for (int i = 0; i < DATA_W; i++) begin
            lanes_bad = lanes_bad + DELTA_W'(diff[i]);
        end
    end

    // Picks the increment for the selected counting mode.
    always_comb begin
        mode = count_mode_e'(block_mode_i);
        if (mode == CNT_BLOCKS) begin
            inc_d = (|diff) ? DELTA_W'(1) : '0;
        end else begin
            inc_d = lanes_bad;
        end
    end

    // Registers the increment of a checked byte for the counter stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inc_vld_o <= 1'b0;
            inc_o     <= '0;
        end else begin
            inc_vld_o <= par_vld_i && ref_vld_i;
            if (par_vld_i) begin
                inc_o <= inc_d;
            end
        end
    end

    AST_BIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        inc_vld_o |-> (inc_o <= DELTA_W'(DATA_W))); // R4
    AST_BLOCK_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (par_vld_i && block_mode_i) |=> (inc_o <= DELTA_W'(1))); // R5
endmodule

// File: rtl/bip8_counter.sv
// Module: running error count with wrap or saturate arithmetic, plus the
// holding register loaded and cleared by the interval strobe.
// Assumes: an increment arriving with the strobe starts the new interval.
module bip8_counter #(
    parameter int CNT_W   = 16,
    parameter int DELTA_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               inc_vld_i,
    input  logic [DELTA_W-1:0] inc_i,
    input  logic               pm_tick_i,
    input  logic               saturate_i,
    output logic [CNT_W-1:0]   hold_o
);
    import bip8_mon_pkg::*;

    localparam int SUM_W = CNT_W + 1;

    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] run_d;
    logic [CNT_W-1:0] base;
    logic [SUM_W-1:0] sum;
    ovf_mode_e        ovf;

    // Builds the next running count: clear on strobe, add, then limit.
    always_comb begin
        ovf  = ovf_mode_e'(saturate_i);
        base = pm_tick_i ? '0 : run_q;
        sum  = {1'b0, base} + (inc_vld_i ? SUM_W'(inc_i) : '0);
        if (ovf == OVF_SATURATE && sum[CNT_W]) begin
            run_d = '1;
        end else begin
            run_d = sum[CNT_W-1:0];
        end
    end

    // Updates the running count every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else begin
            run_q <= run_d;
        end
    end

    // Copies the finished interval count into the holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_o <= '0;
        end else if (pm_tick_i) begin
            hold_o <= run_q;
        end
    end

    AST_PM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_tick_i && !inc_vld_i) |=> (run_q == '0)); // R7
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !pm_tick_i |=> $stable(hold_o)); // R7
    AST_SAT_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        (saturate_i && !pm_tick_i) |=> (run_q >= $past(run_q))); // R9
endmodule

// File: rtl/bip8_path_monitor.sv
// Module: top of the path parity error monitor. Chains the parity fold, the
// one-frame-late check and the interval counter.
// Assumes: bytes are already descrambled and limited to the payload envelope.
module bip8_path_monitor #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start_i,
    input  logic              pay_vld_i,
    input  logic [DATA_W-1:0] pay_data_i,
    input  logic              par_vld_i,
    input  logic [DATA_W-1:0] par_data_i,
    input  logic              pm_tick_i,
    input  logic              block_mode_i,
    input  logic              saturate_i,
    output logic [CNT_W-1:0]  err_hold_o
);
    localparam int DELTA_W = $clog2(DATA_W + 1);

    logic [DATA_W-1:0]  ref_byte;
    logic               ref_vld;
    logic               inc_vld;
    logic [DELTA_W-1:0] inc;

    bip8_accum #(.DATA_W(DATA_W)) u_accum (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_start_i (frame_start_i),
        .pay_vld_i     (pay_vld_i),
        .pay_data_i    (pay_data_i),
        .ref_o         (ref_byte),
        .ref_vld_o     (ref_vld)
    );

    bip8_compare #(.DATA_W(DATA_W), .DELTA_W(DELTA_W)) u_compare (
        .clk          (clk),
        .rst_n        (rst_n),
        .par_vld_i    (par_vld_i),
        .par_data_i   (par_data_i),
        .ref_i        (ref_byte),
        .ref_vld_i    (ref_vld),
        .block_mode_i (block_mode_i),
        .inc_vld_o    (inc_vld),
        .inc_o        (inc)
    );

    bip8_counter #(.CNT_W(CNT_W), .DELTA_W(DELTA_W)) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .inc_vld_i  (inc_vld),
        .inc_i      (inc),
        .pm_tick_i  (pm_tick_i),
        .saturate_i (saturate_i),
        .hold_o     (err_hold_o)
    );
endmodule

// File: tb/test_bip8_path_monitor.sv
module test_bip8_path_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start_i = 1'b0;
    logic        pay_vld_i = 1'b0;
    logic [7:0]  pay_data_i = '0;
    logic        par_vld_i = 1'b0;
    logic [7:0]  par_data_i = '0;
    logic        pm_tick_i = 1'b0;
    logic        block_mode_i = 1'b0;
    logic        saturate_i = 1'b0;
    logic [15:0] err_hold_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    // bench model state
    logic [7:0] m_acc = '0;
    logic [7:0] m_prev = '0;
    bit         m_have_prev = 0;
    bit         m_seen = 0;
    int         m_run = 0;
    int         m_pending = 0;
    int         m_snap = 0;

    always #2 clk = ~clk;

    bip8_path_monitor i_bip8_path_monitor (
        .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start_i),
        .pay_vld_i(pay_vld_i), .pay_data_i(pay_data_i),
        .par_vld_i(par_vld_i), .par_data_i(par_data_i),
        .pm_tick_i(pm_tick_i), .block_mode_i(block_mode_i),
        .saturate_i(saturate_i), .err_hold_o(err_hold_o)
    );

    function automatic int popc(input logic [7:0] v);
        int c = 0;
        for (int i = 0; i < 8; i++) c += int'(v[i]);
        return c;
    endfunction

    function automatic int add_run(input int run, input int inc, input bit sat);
        int s = run + inc;
        if (sat) return (s > 65535) ? 65535 : s;
        return s & 32'hFFFF;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: err_hold_o=%0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            frame_start_i = 0; pay_vld_i = 0; par_vld_i = 0; pm_tick_i = 0;
            if (m_pending >= 0) begin
                m_run = add_run(m_run, m_pending, saturate_i);
                m_pending = -1;
            end
        end
    endtask

    // One frame of len cycles; parity byte at par_pos (if >=0) with lanes
    // flipped by errmask; interval strobe at pm_pos (if >=0).
    task automatic send_frame(input int len, input int par_pos,
                              input logic [7:0] errmask, input int pm_pos);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            frame_start_i = (i == 0);
            pm_tick_i = (i == pm_pos);
            if (i == pm_pos) begin
                m_snap = m_run;
                m_run = 0;
            end
            if (m_pending >= 0) begin
                m_run = add_run(m_run, m_pending, saturate_i);
                m_pending = -1;
            end
            if (i == 0) begin
                m_prev = m_acc;
                m_have_prev = m_seen;
                m_seen = 1;
                m_acc = '0;
            end
            par_vld_i = (i == par_pos);
            if (i == par_pos) begin
                par_data_i = m_prev ^ errmask;
                if (m_have_prev)
                    m_pending = block_mode_i ? int'(errmask != 0) : popc(errmask);
            end else begin
                par_data_i = 8'($urandom);
            end
            pay_vld_i = ($urandom % 4) != 0;
            pay_data_i = 8'($urandom);
            if (pay_vld_i) m_acc ^= pay_data_i;
        end
    endtask

    task automatic pm_check(input string req);
        int exp;
        idle(2);
        exp = m_run;
        @(negedge clk);
        pm_tick_i = 1;
        m_run = 0;
        @(negedge clk);
        pm_tick_i = 0;
        check(err_hold_o == 16'(exp), req, err_hold_o, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: err_hold_o=%0d expected run to finish", err_hold_o);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int unsigned seed = 32'h1B3C;
        void'($urandom(seed));
        m_pending = -1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(err_hold_o == 0, "R1 reset", err_hold_o, 0);
        pm_check("R1 empty interval");

        // R3: parity bytes before any frame and in the first frame count nothing
        @(negedge clk); par_vld_i = 1; par_data_i = 8'hA5;
        @(negedge clk); par_vld_i = 0;
        send_frame(5, 2, 8'hFF, -1);
        pm_check("R3 first frame");
        // R2: correct parity over a random frame adds nothing
        send_frame(7, 3, 8'h00, -1);
        send_frame(4, 1, 8'h00, -1);
        pm_check("R2 clean parity");

        // R4: bit mode counts differing lanes
        send_frame(6, 2, 8'b1011_0001, -1);
        pm_check("R4 four lanes");
        send_frame(3, 1, 8'hFF, -1);
        send_frame(3, 2, 8'h80, -1);
        pm_check("R4 nine lanes");

        // R5: block mode counts one per bad frame
        idle(1); block_mode_i = 1;
        send_frame(5, 1, 8'hFF, -1);
        send_frame(5, 4, 8'h00, -1);
        send_frame(5, 2, 8'h10, -1);
        pm_check("R5 block count");
        idle(1); block_mode_i = 0;

        // R11: parity byte on the frame-start cycle
        send_frame(4, 0, 8'h0F, -1);
        send_frame(1, 0, 8'h03, -1);
        send_frame(3, 0, 8'h00, -1);
        pm_check("R11 parity at frame start");

        // R8: strobe on the edge where the increment enters
        send_frame(6, 1, 8'h07, 2);
        check(err_hold_o == 16'(m_snap), "R8 hold excludes", err_hold_o, m_snap);
        pm_check("R8 carried increment");
        // R6: strobe one edge later includes it
        send_frame(6, 1, 8'h3F, 3);
        check(err_hold_o == 16'(m_snap), "R6 hold includes", err_hold_o, m_snap);
        pm_check("R6 next interval");

        // random mix
        for (int blk = 0; blk < 40; blk++) begin
            idle(1);
            block_mode_i = $urandom % 2;
            for (int f = 0; f < 8; f++) begin
                int len;
                logic [7:0] em;
                len = 1 + ($urandom % 10);
                em = ($urandom % 2) ? 8'($urandom) : 8'h00;
                send_frame(len, $urandom % len, em, -1);
            end
            pm_check(block_mode_i ? "R5 random" : "R4 random");
        end

        // R9: saturation
        idle(1); block_mode_i = 0; saturate_i = 1;
        for (int f = 0; f < 8200; f++) send_frame(1, 0, 8'hFF, -1);
        pm_check("R9 saturate");
        check(m_run == 0, "R9 model", m_run, 0);
        // R10: wrap
        idle(1); saturate_i = 0;
        for (int f = 0; f < 8200; f++) send_frame(1, 0, 8'hFF, -1);
        pm_check("R10 wrap");

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule